// File: doc/BRIEF.md
# APB Requester with Error Capture

This block turns single read or write requests from a simple command port into APB transfers. A request is offered with a valid/ready handshake that carries an address, a direction flag and write data. The block drives one setup cycle and then holds the access phase for as many wait states as the subordinate inserts. The transfer ends on the one clock edge where select, enable and the subordinate's ready are all high.

The subordinate's error flag is read only on that completion edge. Its value is the pass/fail verdict for the access and does not stop the access: a failed transfer is sequenced exactly like a clean one, and nothing is retried or undone. The verdict reaches the requester in two ways. First, a one-cycle response that includes a fault pulse. Second, a sticky log that records the address and direction of the first failure and holds them until the requester clears it. Any recovery is left to the logic above the block.

Top module: `apb_fault_requester`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a clock edge, the block returns to idle. After that edge `m_psel`, `m_penable`, `rsp_done`, `rsp_err`, `rsp_rvalid`, `fault_pulse` and `err_sticky` are low, `err_addr` is zero and `cmd_ready` is high.
- R2: `cmd_ready` is high only while the bus is idle. A request is taken only on an edge where `cmd_valid` and `cmd_ready` are both high. A `cmd_valid` offered during a transfer starts nothing and does not alter the transfer in progress.
- R3: In the cycle after a request is taken, the setup phase shows `m_psel`=1 and `m_penable`=0 for exactly one cycle. The access phase follows with both signals high. `m_paddr`, `m_pwrite` and `m_pwdata` carry the request and stay stable through both phases.
- R4: The access phase continues for any number of cycles in which `s_pready` is low.
- R5: A transfer completes only on an edge with `m_psel`, `m_penable` and `s_pready` all high. In the next cycle `m_psel` is low and `cmd_ready` is high, whether or not an error was flagged.
- R6: `s_pslverr` has no effect outside the completion edge. When it is high during setup or wait cycles, neither `fault_pulse` nor `rsp_err` is raised and the sticky log does not change.
- R7: In the cycle after the completion edge, `rsp_done` is high for exactly one cycle and `rsp_err` equals `s_pslverr` as sampled at that edge. For a read, `rsp_rdata` is `s_prdata` sampled at that edge, even when the read failed, and `rsp_rvalid` is high only if the read had no error. For a write, `rsp_rdata` is zero and `rsp_rvalid` is low.
- R8: `fault_pulse` is high for exactly the one cycle in which `rsp_done` is high, and only when the completed transfer was flagged as an error.
- R9: From the cycle after a failed completion, `err_sticky` is high, `err_addr` holds that transfer's address and `err_write` holds its direction (1 = write). Later failures and clean transfers leave all three unchanged until a clear.
- R10: When `err_clear` is high at an edge, `err_sticky`, `err_addr` and `err_write` read zero from the next cycle on. When a failure completes on the same edge as the clear, that new failure is captured instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Request offered |
| cmd_ready | output | 1 | Request can be taken (idle) |
| cmd_addr | input | AW | Request address |
| cmd_write | input | 1 | Request direction, 1 = write |
| cmd_wdata | input | DW | Request write data |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_err | output | 1 | Completed transfer failed |
| rsp_rvalid | output | 1 | Read data is trustworthy |
| rsp_rdata | output | DW | Read data captured at completion |
| fault_pulse | output | 1 | One-cycle fault indication |
| err_sticky | output | 1 | A failure has been logged |
| err_addr | output | AW | Address of first logged failure |
| err_write | output | 1 | Direction of first logged failure |
| err_clear | input | 1 | Clears the failure log |
| m_psel | output | 1 | APB select |
| m_penable | output | 1 | APB enable |
| m_pwrite | output | 1 | APB direction |
| m_paddr | output | AW | APB address |
| m_pwdata | output | DW | APB write data |
| s_pready | input | 1 | Subordinate ready |
| s_prdata | input | DW | Subordinate read data |
| s_pslverr | input | 1 | Subordinate error flag |

## Verification
The embedded properties check on every cycle that setup is always followed by access and that address and direction hold through wait states. They also check that the bus drops to idle right after a completion edge, that the response strobe and fault pulse occur only one cycle after a completion, and that the sticky log neither loses a captured failure nor survives a clear. Other behaviour depends on data values and can only be shown by the bench scenarios. These are the returned read data on clean and failed reads, error noise during setup and waits that never reaches the outputs, the first-failure capture across a run of later failures, a clear that coincides with a new failure, and a request offered while the bus is busy.

// File: rtl/apb_err_pkg.sv
package apb_err_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } phase_e;

    typedef struct packed {
        logic done;
        logic err;
        logic rvalid;
    } rsp_flags_t;

    function automatic logic is_complete(input logic sel, input logic en, input logic rdy);
        return sel & en & rdy;
    endfunction

endpackage

// File: rtl/apb_err_seq.sv
module apb_err_seq
    import apb_err_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [AW-1:0] cmd_addr,
    input  logic          cmd_write,
    input  logic [DW-1:0] cmd_wdata,
    output logic          m_psel,
    output logic          m_penable,
    output logic          m_pwrite,
    output logic [AW-1:0] m_paddr,
    output logic [DW-1:0] m_pwdata,
    input  logic          s_pready,
    output logic          xfer_done
);

    phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            m_pwrite <= 1'b0;
            m_paddr  <= '0;
            m_pwdata <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (cmd_valid) begin
                        m_pwrite <= cmd_write;
                        m_paddr  <= cmd_addr;
                        m_pwdata <= cmd_wdata;
                        phase    <= PH_SETUP;
                    end
                end
                PH_SETUP:  phase <= PH_ACCESS;
                PH_ACCESS: if (s_pready) phase <= PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    assign cmd_ready = (phase == PH_IDLE);
    assign m_psel    = (phase != PH_IDLE);
    assign m_penable = (phase == PH_ACCESS);
    assign xfer_done = is_complete(m_psel, m_penable, s_pready);

    // R2: a setup phase only follows an accepted request
    assert_setup_needs_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (m_psel && !m_penable) |-> $past(cmd_valid && cmd_ready));

    // R3: setup lasts one cycle and is followed by access
    assert_setup_to_access_R3: assert property (@(posedge clk) disable iff (rst)
        (m_psel && !m_penable) |=> (m_psel && m_penable));

    // R3: address and direction hold across the access phase
    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (m_psel && m_penable) |-> ($stable(m_paddr) && $stable(m_pwrite) && $stable(m_pwdata)));

    // R4: wait states keep the access phase
    assert_wait_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (m_psel && m_penable && !s_pready) |=> (m_psel && m_penable));

    // R5: bus idles right after completion
    assert_idle_after_done_R5: assert property (@(posedge clk) disable iff (rst)
        (m_psel && m_penable && s_pready) |=> (!m_psel && cmd_ready));

endmodule

// File: rtl/apb_err_resp.sv
module apb_err_resp
    import apb_err_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          xfer_done,
    input  logic          xfer_write,
    input  logic          s_pslverr,
    input  logic [DW-1:0] s_prdata,
    output logic          rsp_done,
    output logic          rsp_err,
    output logic          rsp_rvalid,
    output logic [DW-1:0] rsp_rdata,
    output logic          fault_pulse
);

    rsp_flags_t flags_q;
    logic       fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q   <= '0;
            fault_q   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            flags_q.done   <= xfer_done;
            flags_q.err    <= xfer_done & s_pslverr;
            flags_q.rvalid <= xfer_done & ~xfer_write & ~s_pslverr;
            fault_q        <= xfer_done & s_pslverr;
            rsp_rdata      <= (xfer_done && !xfer_write) ? s_prdata : '0;
        end
    end

    assign rsp_done    = flags_q.done;
    assign rsp_err     = flags_q.err;
    assign rsp_rvalid  = flags_q.rvalid;
    assign fault_pulse = fault_q;

    // R7: a response strobe follows every completion
    assert_done_follows_R7: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> rsp_done);

    // R7: no response strobe without a completion
    assert_done_only_after_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(xfer_done));

    // R8: fault pulse matches the verdict sampled at completion
    assert_fault_verdict_R8: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> (fault_pulse == $past(s_pslverr)));

    // R6: error flag outside a completion never raises a fault
    assert_ignore_noise_R6: assert property (@(posedge clk) disable iff (rst)
        !xfer_done |=> (!fault_pulse && !rsp_err));

endmodule

// File: rtl/apb_err_log.sv
module apb_err_log #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          xfer_done,
    input  logic          s_pslverr,
    input  logic [AW-1:0] xfer_addr,
    input  logic          xfer_write,
    input  logic          err_clear,
    output logic          err_sticky,
    output logic [AW-1:0] err_addr,
    output logic          err_write
);

    logic fail_now;
    assign fail_now = xfer_done & s_pslverr;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_sticky <= 1'b0;
            err_addr   <= '0;
            err_write  <= 1'b0;
        end else if (fail_now && (!err_sticky || err_clear)) begin
            err_sticky <= 1'b1;
            err_addr   <= xfer_addr;
            err_write  <= xfer_write;
        end else if (err_clear) begin
            err_sticky <= 1'b0;
            err_addr   <= '0;
            err_write  <= 1'b0;
        end
    end

    // R9: a failed completion is always logged
    assert_capture_R9: assert property (@(posedge clk) disable iff (rst)
        fail_now |=> err_sticky);

    // R9: the first logged failure is held until cleared
    assert_hold_first_R9: assert property (@(posedge clk) disable iff (rst)
        (err_sticky && !err_clear) |=> (err_sticky && $stable(err_addr) && $stable(err_write)));

    // R10: a clear without a coinciding failure empties the log
    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (err_clear && !fail_now) |=> !err_sticky);

endmodule

// File: rtl/apb_fault_requester.sv
module apb_fault_requester
    import apb_err_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [AW-1:0] cmd_addr,
    input  logic          cmd_write,
    input  logic [DW-1:0] cmd_wdata,
    output logic          rsp_done,
    output logic          rsp_err,
    output logic          rsp_rvalid,
    output logic [DW-1:0] rsp_rdata,
    output logic          fault_pulse,
    output logic          err_sticky,
    output logic [AW-1:0] err_addr,
    output logic          err_write,
    input  logic          err_clear,
    output logic          m_psel,
    output logic          m_penable,
    output logic          m_pwrite,
    output logic [AW-1:0] m_paddr,
    output logic [DW-1:0] m_pwdata,
    input  logic          s_pready,
    input  logic [DW-1:0] s_prdata,
    input  logic          s_pslverr
);

    logic xfer_done;

    apb_err_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_addr  (cmd_addr),
        .cmd_write (cmd_write),
        .cmd_wdata (cmd_wdata),
        .m_psel    (m_psel),
        .m_penable (m_penable),
        .m_pwrite  (m_pwrite),
        .m_paddr   (m_paddr),
        .m_pwdata  (m_pwdata),
        .s_pready  (s_pready),
        .xfer_done (xfer_done)
    );

    apb_err_resp #(.DW(DW)) u_resp (
        .clk         (clk),
        .rst         (rst),
        .xfer_done   (xfer_done),
        .xfer_write  (m_pwrite),
        .s_pslverr   (s_pslverr),
        .s_prdata    (s_prdata),
        .rsp_done    (rsp_done),
        .rsp_err     (rsp_err),
        .rsp_rvalid  (rsp_rvalid),
        .rsp_rdata   (rsp_rdata),
        .fault_pulse (fault_pulse)
    );

    apb_err_log #(.AW(AW)) u_log (
        .clk        (clk),
        .rst        (rst),
        .xfer_done  (xfer_done),
        .s_pslverr  (s_pslverr),
        .xfer_addr  (m_paddr),
        .xfer_write (m_pwrite),
        .err_clear  (err_clear),
        .err_sticky (err_sticky),
        .err_addr   (err_addr),
        .err_write  (err_write)
    );

    // R8: a fault pulse only accompanies a response strobe
    assert_fault_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> (rsp_done && rsp_err));

endmodule

// File: tb/apb_fault_requester_test.sv
module apb_fault_requester_test;

    localparam int AW = 16;
    localparam int DW = 32;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [3:0]    waits;
        logic          err;
        logic          noise;
        logic [DW-1:0] rdata;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'h0010, 32'h0,         4'd0, 1'b0, 1'b0, 32'hA5A5_0001},
        '{1'b1, 16'h0020, 32'h1111_2222, 4'd2, 1'b0, 1'b1, 32'h0},
        '{1'b0, 16'h0030, 32'h0,         4'd3, 1'b1, 1'b0, 32'hDEAD_BEEF},
        '{1'b1, 16'h0040, 32'h3333_4444, 4'd0, 1'b1, 1'b0, 32'h0},
        '{1'b0, 16'h0050, 32'h0,         4'd1, 1'b0, 1'b1, 32'h0000_1234},
        '{1'b1, 16'h0060, 32'h5555_6666, 4'd5, 1'b0, 1'b1, 32'h0},
        '{1'b0, 16'h0070, 32'h0,         4'd0, 1'b0, 1'b1, 32'hFFFF_0000},
        '{1'b1, 16'h0080, 32'h7777_8888, 4'd4, 1'b1, 1'b1, 32'h0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_write = 1'b0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          rsp_done, rsp_err, rsp_rvalid, fault_pulse;
    logic [DW-1:0] rsp_rdata;
    logic          err_sticky, err_write;
    logic [AW-1:0] err_addr;
    logic          err_clear = 1'b0;
    logic          m_psel, m_penable, m_pwrite;
    logic [AW-1:0] m_paddr;
    logic [DW-1:0] m_pwdata;
    logic          s_pready = 1'b0;
    logic [DW-1:0] s_prdata = '0;
    logic          s_pslverr = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    logic          exp_sticky = 1'b0;
    logic [AW-1:0] exp_eaddr = '0;
    logic          exp_ewr = 1'b0;

    always #4 clk = ~clk;

    apb_fault_requester #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rvalid(rsp_rvalid),
        .rsp_rdata(rsp_rdata), .fault_pulse(fault_pulse),
        .err_sticky(err_sticky), .err_addr(err_addr), .err_write(err_write),
        .err_clear(err_clear),
        .m_psel(m_psel), .m_penable(m_penable), .m_pwrite(m_pwrite),
        .m_paddr(m_paddr), .m_pwdata(m_pwdata),
        .s_pready(s_pready), .s_prdata(s_prdata), .s_pslverr(s_pslverr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_log(input string req);
        chk(err_sticky == exp_sticky, req, "err_sticky", 64'(err_sticky), 64'(exp_sticky));
        chk(err_addr == exp_eaddr, req, "err_addr", 64'(err_addr), 64'(exp_eaddr));
        chk(err_write == exp_ewr, req, "err_write", 64'(err_write), 64'(exp_ewr));
    endtask

    // One transfer; inputs change at falling edges, outputs are sampled there too.
    task automatic run_xfer(input vec_t v, input logic clr_at_done, input logic busy_offer);
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R2", "cmd_ready idle", 64'(cmd_ready), 64'd1);
        cmd_valid = 1'b1; cmd_addr = v.addr; cmd_write = v.wr; cmd_wdata = v.wdata;
        @(negedge clk);
        // setup phase
        if (busy_offer) begin
            cmd_addr = v.addr ^ 16'hFFFF; cmd_write = ~v.wr;
        end else begin
            cmd_valid = 1'b0;
        end
        s_pready = 1'b0; s_pslverr = v.noise;
        chk(m_psel && !m_penable, "R3", "setup phase", {62'd0, m_psel, m_penable}, 64'b10);
        chk(m_paddr == v.addr && m_pwrite == v.wr, "R3", "setup addr",
            64'(m_paddr), 64'(v.addr));
        chk(cmd_ready == 1'b0, "R2", "cmd_ready busy", 64'(cmd_ready), 64'd0);
        for (int i = 0; i < int'(v.waits); i++) begin
            @(negedge clk);
            s_pready = 1'b0; s_pslverr = v.noise;
            chk(m_psel && m_penable, "R4", "wait access", {62'd0, m_psel, m_penable}, 64'b11);
            chk(m_paddr == v.addr && m_pwdata == v.wdata, "R3", "stable during wait",
                64'(m_paddr), 64'(v.addr));
            chk(!fault_pulse && !rsp_done, "R6", "no response during wait",
                {62'd0, fault_pulse, rsp_done}, 64'd0);
            chk_log("R6");
        end
        @(negedge clk);
        chk(m_psel && m_penable, "R3", "access phase", {62'd0, m_psel, m_penable}, 64'b11);
        chk(!fault_pulse && !rsp_done, "R6", "no response before completion",
            {62'd0, fault_pulse, rsp_done}, 64'd0);
        if (busy_offer) cmd_valid = 1'b0;
        s_pready = 1'b1; s_pslverr = v.err; s_prdata = v.rdata; err_clear = clr_at_done;
        if (v.err && (!exp_sticky || clr_at_done)) begin
            exp_sticky = 1'b1; exp_eaddr = v.addr; exp_ewr = v.wr;
        end else if (clr_at_done) begin
            exp_sticky = 1'b0; exp_eaddr = '0; exp_ewr = 1'b0;
        end
        @(negedge clk);
        s_pready = 1'b0; s_pslverr = 1'b0; s_prdata = 32'hBAD0_BAD0; err_clear = 1'b0;
        chk(!m_psel && cmd_ready, "R5", "idle after completion", {62'd0, m_psel, cmd_ready}, 64'b01);
        chk(rsp_done == 1'b1, "R7", "rsp_done", 64'(rsp_done), 64'd1);
        chk(rsp_err == v.err, "R7", "rsp_err", 64'(rsp_err), 64'(v.err));
        chk(rsp_rdata == (v.wr ? 32'h0 : v.rdata), "R7", "rsp_rdata",
            64'(rsp_rdata), 64'(v.wr ? 32'h0 : v.rdata));
        chk(rsp_rvalid == (!v.wr && !v.err), "R7", "rsp_rvalid",
            64'(rsp_rvalid), 64'(!v.wr && !v.err));
        chk(fault_pulse == v.err, "R8", "fault_pulse", 64'(fault_pulse), 64'(v.err));
        chk_log(clr_at_done ? "R10" : "R9");
        @(negedge clk);
        chk(!rsp_done && !fault_pulse, "R8", "pulse one cycle",
            {62'd0, rsp_done, fault_pulse}, 64'd0);
        chk(!m_psel, "R2", "no start from busy offer", 64'(m_psel), 64'd0);
        chk_log("R9");
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(!m_psel && !m_penable, "R1", "bus idle", {62'd0, m_psel, m_penable}, 64'd0);
        chk(cmd_ready, "R1", "cmd_ready", 64'(cmd_ready), 64'd1);
        chk(!rsp_done && !rsp_err && !rsp_rvalid && !fault_pulse, "R1", "response low",
            {60'd0, rsp_done, rsp_err, rsp_rvalid, fault_pulse}, 64'd0);
        chk_log("R1");

        // table walk: R3 R4 R5 R6 R7 R8 R9
        for (int k = 0; k < NV; k++) run_xfer(VEC[k], 1'b0, 1'b0);

        // R10: standalone clear
        @(negedge clk);
        err_clear = 1'b1;
        exp_sticky = 1'b0; exp_eaddr = '0; exp_ewr = 1'b0;
        @(negedge clk);
        err_clear = 1'b0;
        chk_log("R10");

        // R9: clean transfer after clear leaves the log empty
        run_xfer(VEC[0], 1'b0, 1'b0);

        // R9 then R10: log a write failure, then clear on the edge of a new read failure
        run_xfer('{1'b1, 16'h0ABC, 32'hCAFE_0001, 4'd1, 1'b1, 1'b1, 32'h0}, 1'b0, 1'b0);
        run_xfer('{1'b0, 16'h0DEF, 32'h0, 4'd2, 1'b1, 1'b1, 32'h0BAD_F00D}, 1'b1, 1'b0);

        // R2: request held with changing fields while busy
        run_xfer('{1'b0, 16'h0123, 32'h0, 4'd3, 1'b0, 1'b1, 32'h1357_9BDF}, 1'b0, 1'b1);

        // R1: reset in the middle of an access
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = 16'h0555; cmd_write = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_sticky = 1'b0; exp_eaddr = '0; exp_ewr = 1'b0;
        chk(!m_psel && !m_penable && cmd_ready, "R1", "reset mid access",
            {61'd0, m_psel, m_penable, cmd_ready}, 64'b001);
        chk_log("R1");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule